// File: doc/BRIEF.md
# Multi-Stream Synchronized Start Gate

This block decides, once per link frame, which of eight DMA stream engines may move data over the serial link. Streams 0 to 3 are input (capture) streams and streams 4 to 7 are output (playback) streams. Each stream has a RUN request and a FIFO-ready flag. Each stream also has a hold bit in a software-visible hold register. At every frame-start pulse, the block drives a stream's transfer-active output high only if that stream is running, is not held and has its FIFO ready.

To start a group of streams together, software first sets their hold bits and then sets their RUN bits. Once the FIFOs report ready, software clears all the hold bits with one write. Every released stream then turns on at the same frame boundary. To stop a group together, software sets the hold bits first and then clears RUN. A stream whose hold bit stays 0 starts at the first frame after its RUN goes high.

A 32-bit wall clock counter advances once per link bit clock while the bit-clock enable is high. It can be read over the register bus, so that several controllers can align to a shared time base. It is also driven on a port.

Top module: `stream_start_gate`

## Requirements
- R1: After reset, the hold register reads 0, the wall clock reads 0 and all eight transfer-active outputs are 0.
- R2: The hold register sits at byte offset 34h. It is read/write in bits 7:0, and bits 31:8 always read as 0.
- R3: The transfer-active outputs change only on a clock edge where frame_start is 1. They hold their value at every other edge.
- R4: At a frame_start edge, stream i becomes active when its RUN bit is 1, its hold bit (bit i) is 0 and its FIFO-ready bit is 1.
- R5: At a frame_start edge, a stream whose hold bit is 1, whose RUN is 0 or whose FIFO-ready is 0 becomes inactive. It stays inactive through a stop sequence that sets the hold bit and then clears RUN.
- R6: Streams released by one write that clears several hold bits all turn on at the same next frame_start edge, and none turns on before that edge.
- R7: When a hold-register write and a frame_start fall on the same edge, the frame decision uses the hold value from before the write for every bit. The new value first applies at the following frame.
- R8: The wall clock at offset 30h increases by 1 at each clock edge where bclk_en is 1 and stays unchanged when bclk_en is 0. Writes to offset 30h have no effect.
- R9: The wall clock wraps from its all-ones value to 0.
- R10: Reads of any offset other than 30h and 34h return 0. Writes to those offsets change neither the hold register nor the wall clock.
- R11: Hold bit i, RUN bit i, FIFO-ready bit i and active bit i all belong to stream i. Bits 0–3 are input streams 1–4 and bits 4–7 are output streams 1–4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| bus_addr | input | 8 | Register byte offset, used for both read and write |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| strm_run | input | 8 | Per-stream RUN request |
| strm_fifo_rdy | input | 8 | Per-stream FIFO-ready flag |
| bclk_en | input | 1 | Bit-clock enable; the wall clock counts while this is 1 |
| frame_start | input | 1 | One-cycle pulse at the start of each link frame |
| strm_active | output | 8 | Per-stream transfer-active grant |
| wall_time | output | 32 | Current wall clock value |

## Verification
A hold-register write becomes visible on bus_rdata one edge after the strobe, because the read path is combinational. A wall clock read taken after n enabled edges shows exactly n counts. A transfer-active change appears right after the frame_start edge that decides it, and never at any other edge. The bench drives every input on the falling clock edge and samples one falling edge later, so each check sees exactly one rising edge's worth of change. Checks taken between a hold-register write and the next frame confirm that nothing moves early. The wrap check runs on a second instance with an 8-bit counter, so that it can reach the all-ones value in a few hundred cycles.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
   localparam int unsigned DEF_IN_STREAMS  = 4;
   localparam int unsigned DEF_OUT_STREAMS = 4;
   localparam int unsigned DEF_ADDR_W      = 8;
   localparam int unsigned DEF_DATA_W      = 32;
   localparam int unsigned DEF_WCLK_W      = 32;
   localparam int unsigned DEF_OFS_WCLK    = 'h30;
   localparam int unsigned DEF_OFS_HOLD    = 'h34;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_WCLK = 2'd1,
      SEL_HOLD = 2'd2
   } sgate_sel_e;
endpackage

// File: rtl/sgate_wallclk.sv
module sgate_wallclk #(
   parameter int unsigned WCLK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   output logic [WCLK_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (cnt_en)
         count <= count + 1'b1;   // natural modulo wrap
   end
endmodule

// File: rtl/sgate_regs.sv
module sgate_regs
   import sgate_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NSTR     = 8,
   parameter int unsigned WCLK_W   = 32,
   parameter int unsigned OFS_WCLK = 'h30,
   parameter int unsigned OFS_HOLD = 'h34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [WCLK_W-1:0] wclk_val,
   output logic [NSTR-1:0]   hold_q,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_WCLK = ADDR_W'(OFS_WCLK);
   localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(OFS_HOLD);

   sgate_sel_e sel;

   always_comb begin
      if (addr == A_HOLD)
         sel = SEL_HOLD;
      else if (addr == A_WCLK)
         sel = SEL_WCLK;
      else
         sel = SEL_NONE;
   end

   // hold register: only the stream bits exist
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (wr && sel == SEL_HOLD)
         hold_q <= wdata[NSTR-1:0];
   end

   logic [DATA_W-1:0] hold_ext;
   logic [DATA_W-1:0] wclk_ext;

   generate
      if (DATA_W > NSTR) begin : g_hold_pad
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata[DATA_W-1:NSTR];
         assign hold_ext = {{(DATA_W-NSTR){1'b0}}, hold_q};
      end else begin : g_hold_full
         assign hold_ext = hold_q;
      end

      if (DATA_W > WCLK_W) begin : g_wclk_pad
         assign wclk_ext = {{(DATA_W-WCLK_W){1'b0}}, wclk_val};
      end else begin : g_wclk_full
         assign wclk_ext = wclk_val;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_HOLD: rdata = hold_ext;
         SEL_WCLK: rdata = wclk_ext;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/sgate_gate.sv
module sgate_gate #(
   parameter int unsigned NSTR = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame,
   input  logic [NSTR-1:0] run,
   input  logic [NSTR-1:0] fifo_rdy,
   input  logic [NSTR-1:0] hold,
   output logic [NSTR-1:0] active
);
   // one grant flop per stream, decided only at frame boundaries
   generate
      for (genvar s = 0; s < NSTR; s++) begin : g_strm
         logic grant_d;
         assign grant_d = run[s] & ~hold[s] & fifo_rdy[s];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               active[s] <= 1'b0;
            else if (frame)
               active[s] <= grant_d;
         end
      end
   endgenerate
endmodule

// File: rtl/stream_start_gate.sv
module stream_start_gate
   import sgate_pkg::*;
#(
   parameter int unsigned IN_STREAMS  = DEF_IN_STREAMS,
   parameter int unsigned OUT_STREAMS = DEF_OUT_STREAMS,
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned WCLK_W      = DEF_WCLK_W,
   parameter int unsigned OFS_WCLK    = DEF_OFS_WCLK,
   parameter int unsigned OFS_HOLD    = DEF_OFS_HOLD,
   localparam int unsigned NSTR       = IN_STREAMS + OUT_STREAMS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSTR-1:0]   strm_run,
   input  logic [NSTR-1:0]   strm_fifo_rdy,
   input  logic              bclk_en,
   input  logic              frame_start,
   output logic [NSTR-1:0]   strm_active,
   output logic [WCLK_W-1:0] wall_time
);
   // elaboration-time parameter checks
   generate
      if (NSTR < 1 || NSTR > DATA_W) begin : g_bad_nstr
         $error("stream count must be 1..DATA_W");
      end
      if (WCLK_W < 2 || WCLK_W > DATA_W) begin : g_bad_wclk
         $error("WCLK_W must be 2..DATA_W");
      end
      if (OFS_WCLK == OFS_HOLD || OFS_WCLK >= (1 << ADDR_W) || OFS_HOLD >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("register offsets must differ and fit ADDR_W");
      end
   endgenerate

   logic [NSTR-1:0]   sync_q;
   logic [WCLK_W-1:0] wclk_q;

   sgate_wallclk #(.WCLK_W(WCLK_W)) u_wclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_en (bclk_en),
      .count  (wclk_q)
   );

   sgate_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NSTR     (NSTR),
      .WCLK_W   (WCLK_W),
      .OFS_WCLK (OFS_WCLK),
      .OFS_HOLD (OFS_HOLD)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .wclk_val (wclk_q),
      .hold_q   (sync_q),
      .rdata    (bus_rdata)
   );

   // the gate sees the registered hold value, so a write landing on a
   // frame edge is applied atomically at the following frame
   sgate_gate #(.NSTR(NSTR)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame    (frame_start),
      .run      (strm_run),
      .fifo_rdy (strm_fifo_rdy),
      .hold     (sync_q),
      .active   (strm_active)
   );

   assign wall_time = wclk_q;
endmodule

// File: rtl/sgate_chk.sv
module sgate_chk #(
   parameter int unsigned NSTR     = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WCLK_W   = 32,
   parameter int unsigned OFS_WCLK = 'h30,
   parameter int unsigned OFS_HOLD = 'h34
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              bclk_en,
   input logic [NSTR-1:0]   strm_run,
   input logic [NSTR-1:0]   strm_fifo_rdy,
   input logic [NSTR-1:0]   strm_active,
   input logic [NSTR-1:0]   sync_q,
   input logic [WCLK_W-1:0] wclk_q,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] A_WCLK = ADDR_W'(OFS_WCLK);
   localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(OFS_HOLD);

   // R3
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(strm_active));

   // R4
   grant_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> ((strm_active | ~$past(strm_run & strm_fifo_rdy & ~sync_q)) == '1));

   // R5
   block_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> ((strm_active & $past(sync_q | ~strm_run | ~strm_fifo_rdy)) == '0));

   // R8
   wclk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bclk_en |=> wclk_q == WCLK_W'($past(wclk_q) + 1'b1));

   // R8
   wclk_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_en |=> $stable(wclk_q));

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != A_WCLK && bus_addr != A_HOLD) |-> bus_rdata == '0);

   // R2
   hold_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_HOLD |-> (bus_rdata >> NSTR) == '0);
endmodule

bind stream_start_gate sgate_chk #(
   .NSTR     (NSTR),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .WCLK_W   (WCLK_W),
   .OFS_WCLK (OFS_WCLK),
   .OFS_HOLD (OFS_HOLD)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_start   (frame_start),
   .bclk_en       (bclk_en),
   .strm_run      (strm_run),
   .strm_fifo_rdy (strm_fifo_rdy),
   .strm_active   (strm_active),
   .sync_q        (sync_q),
   .wclk_q        (wclk_q),
   .bus_addr      (bus_addr),
   .bus_rdata     (bus_rdata)
);

// File: tb/stream_start_gate_test.sv
module stream_start_gate_test;
   localparam logic [7:0] A_WCLK = 8'h30;
   localparam logic [7:0] A_HOLD = 8'h34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  strm_run = '0;
   logic [7:0]  strm_fifo_rdy = '0;
   logic        bclk_en = 1'b0;
   logic        frame_start = 1'b0;
   logic [7:0]  strm_active;
   logic [31:0] wall_time;

   logic        sm_en = 1'b0;
   logic [31:0] sm_rdata;
   logic [7:0]  sm_active;
   logic [7:0]  sm_time;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;   // 250 MHz

   stream_start_gate uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strm_run(strm_run),
      .strm_fifo_rdy(strm_fifo_rdy), .bclk_en(bclk_en),
      .frame_start(frame_start), .strm_active(strm_active),
      .wall_time(wall_time)
   );

   // narrow counter instance for the wrap check
   stream_start_gate #(.WCLK_W(8)) uut_w (
      .clk(clk), .rst_n(rst_n), .bus_addr(A_WCLK), .bus_wr(1'b0),
      .bus_wdata(32'h0), .bus_rdata(sm_rdata), .strm_run(8'h00),
      .strm_fifo_rdy(8'h00), .bclk_en(sm_en), .frame_start(1'b0),
      .strm_active(sm_active), .wall_time(sm_time)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_read(A_HOLD, d); chk("R1 hold", d, 0);
      bus_read(A_WCLK, d); chk("R1 wclk", d, 0);
      chk("R1 active", {24'h0, strm_active}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      bus_write(A_HOLD, 32'hFFFF_FFFF);
      bus_read(A_HOLD, d); chk("R2 reserved zero", d, 32'h0000_00FF);
      bus_write(A_HOLD, 32'h1234_56A5);
      bus_read(A_HOLD, d); chk("R2 readback", d, 32'h0000_00A5);
   endtask

   task automatic t_unmapped();
      logic [31:0] d, w0;
      bus_read(A_WCLK, w0);
      bus_write(8'h38, 32'hFFFF_FFFF);
      bus_write(8'h00, 32'h0000_0000);
      bus_read(8'h38, d); chk("R10 read unmapped", d, 0);
      bus_read(8'h33, d); chk("R10 read unmapped 33h", d, 0);
      bus_read(A_HOLD, d); chk("R10 hold untouched", d, 32'hA5);
      bus_read(A_WCLK, d); chk("R10 wclk untouched", d, w0);
   endtask

   task automatic t_wallclk();
      logic [31:0] d, w0;
      bus_read(A_WCLK, w0);
      @(negedge clk); bclk_en = 1'b1;
      repeat (5) @(negedge clk);
      bclk_en = 1'b0;
      bus_read(A_WCLK, d); chk("R8 count 5", d, w0 + 5);
      repeat (3) @(negedge clk);
      bus_read(A_WCLK, d); chk("R8 frozen", d, w0 + 5);
      chk("R8 port", wall_time, w0 + 5);
      bus_write(A_WCLK, 32'h1234_5678);
      bus_read(A_WCLK, d); chk("R8 write ignored", d, w0 + 5);
   endtask

   task automatic t_free_run();
      bus_write(A_HOLD, 32'h0);
      strm_run = 8'h01; strm_fifo_rdy = 8'hFF;
      @(negedge clk);
      chk("R3 no frame yet", {24'h0, strm_active}, 0);
      frame();
      chk("R4 unheld start", {24'h0, strm_active}, 32'h01);
      strm_run = 8'h10;
      @(negedge clk);
      chk("R3 hold between frames", {24'h0, strm_active}, 32'h01);
      frame();
      chk("R11 output stream 1 is bit 4", {24'h0, strm_active}, 32'h10);
      strm_run = 8'h10; strm_fifo_rdy = 8'h00;
      frame();
      chk("R5 fifo not ready", {24'h0, strm_active}, 0);
   endtask

   task automatic t_sync_start();
      bus_write(A_HOLD, 32'hFF);
      strm_run = 8'hFF; strm_fifo_rdy = 8'hFF;
      frame();
      chk("R5 all held", {24'h0, strm_active}, 0);
      bus_write(A_HOLD, 32'h00);
      @(negedge clk);
      chk("R6 nothing before frame", {24'h0, strm_active}, 0);
      frame();
      chk("R6 released together", {24'h0, strm_active}, 32'hFF);
   endtask

   task automatic t_atomic();
      bus_write(A_HOLD, 32'h0F);
      frame();
      chk("R11 inputs held", {24'h0, strm_active}, 32'hF0);
      @(negedge clk);
      bus_addr = A_HOLD; bus_wdata = 32'h0; bus_wr = 1'b1; frame_start = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; frame_start = 1'b0;
      chk("R7 old hold value used", {24'h0, strm_active}, 32'hF0);
      frame();
      chk("R7 new value next frame", {24'h0, strm_active}, 32'hFF);
   endtask

   task automatic t_stop();
      bus_write(A_HOLD, 32'h33);
      @(negedge clk);
      chk("R3 stop waits for frame", {24'h0, strm_active}, 32'hFF);
      frame();
      chk("R5 held streams stop", {24'h0, strm_active}, 32'hCC);
      strm_run = 8'hCC;
      frame();
      chk("R5 stay stopped after RUN clear", {24'h0, strm_active}, 32'hCC);
      strm_run = 8'h00;
      frame();
      chk("R5 run cleared", {24'h0, strm_active}, 0);
   endtask

   task automatic t_wrap();
      @(negedge clk); sm_en = 1'b1;
      repeat (255) @(negedge clk);
      sm_en = 1'b0;
      chk("R9 all ones", sm_rdata, 32'h0000_00FF);
      @(negedge clk); sm_en = 1'b1;
      @(negedge clk); sm_en = 1'b0;
      chk("R9 wrap to zero", sm_rdata, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_regs();
      t_unmapped();
      t_wallclk();
      t_free_run();
      t_sync_start();
      t_atomic();
      t_stop();
      t_wrap();
      summary();
      $finish;
   end
endmodule